// File: doc/BRIEF.md
# Partitioned SIMD Equality Comparator

This block compares two operands that are cut into equal-width lanes (by default four lanes of 8 bits, 32 bits in all) and reports equality per SIMD element. A partition vector with one bit per lane boundary picks the element layout at run time. Any run of lanes whose boundaries are closed forms one wider element: two lanes make a 16-bit element and four lanes make a 32-bit element. Every lane first compares its own bytes. The lane flags of each element are then ANDed together, and the element's verdict appears on the output bit of its lowest lane. Output bits that belong to the upper lanes of a merged element read zero.

The result is registered once. A two-state output controller, with states `OS_IDLE` (no fresh result) and `OS_LOAD` (a result was captured on the last edge), raises `out_valid` one clock after a request is accepted. The controller goes to `OS_LOAD` whenever `in_valid` is sampled high. It returns to `OS_IDLE` whenever `in_valid` is sampled low, from either state. While idle, the result register keeps its last value.

Top module: `simd_eq_cmp`

## Requirements
- R1: Lane i spans operand bits [8i+7:8i]. Its equality flag is 1 exactly when all 8 bits of `op_a` and `op_b` in that lane match, so a single flipped bit in a lane clears that lane's flag.
- R2: Partition bit N sits on the boundary between lane N and lane N+1. A value of 1 splits the two lanes into separate elements, and 0 joins them into one element.
- R3: With `part` = 000, `eq_out` = {000, op_a == op_b} (one 32-bit compare).
- R4: With `part` = 111, `eq_out[i]` is the flag of lane i for every lane (four 8-bit compares).
- R5: For every partition pattern, the output bit of an element's lowest lane is the AND of the flags of all lanes in that element.
- R6: An output bit i > 0 whose partition bit i-1 is 0 (not the lowest lane of an element) is 0.
- R7: `out_valid` equals `in_valid` as sampled on the previous rising clock edge (states `OS_LOAD` / `OS_IDLE`), and `eq_out` shows the result for the inputs sampled on that edge.
- R8: While `rst_n` is low, `out_valid` and `eq_out` are 0.
- R9: A clock edge with `in_valid` low leaves `eq_out` unchanged, whatever the operands and partition bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request: capture a new comparison on this edge |
| op_a | input | 32 | First operand, lane i in bits [8i+7:8i] |
| op_b | input | 32 | Second operand, same lane layout |
| part | input | 3 | Boundary bits; bit N = 1 splits lanes N and N+1 |
| eq_out | output | 4 | Per-element equality, on each element's lowest lane bit |
| out_valid | output | 1 | High in the cycle after an accepted request |

## Verification
Every result appears exactly one rising edge after the inputs are sampled: `eq_out` and `out_valid` change on the edge that captures the request and are then stable for a whole cycle. The bench drives each stimulus on a falling edge. On the next falling edge it compares the outputs against a behavioural model entry that was computed when the stimulus was driven, so each comparison lines up with the single register stage. Cycles with `in_valid` low keep the previous model result, which tests the hold behaviour with the same one-cycle alignment.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;

    localparam int unsigned DEF_LANE_W = 8;
    localparam int unsigned DEF_LANES  = 4;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_LOAD = 1'b1
    } out_state_e;

endpackage

// File: rtl/simd_lane_eq.sv
module simd_lane_eq #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [LANES-1:0]  lane_eq
);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign lane_eq[gi] = (op_a[gi*LANE_W +: LANE_W] == op_b[gi*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/simd_group_merge.sv
module simd_group_merge #(
    parameter int unsigned LANES = 4,
    localparam int unsigned PART_W = LANES - 1
) (
    input  logic [LANES-1:0]  lane_eq,
    input  logic [PART_W-1:0] part,
    output logic [LANES-1:0]  grp_eq
);

    // run[i]: AND of lane flags from lane i up to the end of its element
    logic [LANES-1:0] run;
    logic [LANES-1:0] head;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_chain
        if (gi == LANES - 1) begin : g_top
            assign run[gi] = lane_eq[gi];
        end else begin : g_mid
            assign run[gi] = lane_eq[gi] & (part[gi] | run[gi+1]);
        end

        if (gi == 0) begin : g_first
            assign head[gi] = 1'b1;
        end else begin : g_rest
            assign head[gi] = part[gi-1];
        end

        assign grp_eq[gi] = head[gi] & run[gi];
    end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage
    import simd_eq_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q,
    output logic             q_valid
);

    out_state_e state_q, state_d;
    logic [LANES-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: state_d = in_valid ? OS_LOAD : OS_IDLE;
            OS_LOAD: state_d = in_valid ? OS_LOAD : OS_IDLE;
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (in_valid) begin
            data_q <= d;
        end
    end

    always_comb begin
        q       = data_q;
        q_valid = (state_q == OS_LOAD);
    end

endmodule

// File: rtl/simd_eq_cmp.sv
module simd_eq_cmp
    import simd_eq_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned PART_W = LANES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [PART_W-1:0] part,
    output logic [LANES-1:0]  eq_out,
    output logic              out_valid
);

    logic [LANES-1:0] lane_eq;
    logic [LANES-1:0] grp_eq;

    simd_lane_eq #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_lane_eq (
        .op_a    (op_a),
        .op_b    (op_b),
        .lane_eq (lane_eq)
    );

    simd_group_merge #(
        .LANES (LANES)
    ) u_merge (
        .lane_eq (lane_eq),
        .part    (part),
        .grp_eq  (grp_eq)
    );

    simd_out_stage #(
        .LANES (LANES)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (grp_eq),
        .q        (eq_out),
        .q_valid  (out_valid)
    );

endmodule

// File: rtl/simd_eq_cmp_chk.sv
module simd_eq_cmp_chk #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned PART_W = LANES - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [PART_W-1:0] part,
    input logic [LANES-1:0]  eq_out,
    input logic              out_valid
);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && eq_out == '0));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(eq_out));

    // R6
    non_head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> ((eq_out & ~{$past(part), 1'b1}) == '0));

    // R3
    full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && (part == '0)) |->
            (eq_out == {{(LANES-1){1'b0}}, $past(op_a == op_b)}));

    for (genvar gi = 0; gi < LANES; gi++) begin : g_open
        // R4
        all_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && (&part)) |->
                (eq_out[gi] == ($past(op_a[gi*LANE_W +: LANE_W]) ==
                                $past(op_b[gi*LANE_W +: LANE_W]))));
    end

endmodule

bind simd_eq_cmp simd_eq_cmp_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .part      (part),
    .eq_out    (eq_out),
    .out_valid (out_valid)
);

// File: tb/simd_eq_cmp_bench.sv
module simd_eq_cmp_bench;

    localparam int LW = 8;
    localparam int NL = 4;
    localparam int DW = LW * NL;
    localparam int PW = NL - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [PW-1:0] part = '0;
    logic [NL-1:0] eq_out;
    logic          out_valid;

    int checks = 0;
    int fails  = 0;

    // model state: what the outputs must show at the next compare point
    logic [NL-1:0] exp_eq  = '0;
    logic          exp_vld = 1'b0;
    logic [PW-1:0] exp_part = '0;
    string         exp_tag = "R8";

    always #5 clk = ~clk;

    simd_eq_cmp u_simd_eq_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .part      (part),
        .eq_out    (eq_out),
        .out_valid (out_valid)
    );

    function automatic logic [NL-1:0] model_eq(logic [DW-1:0] a, logic [DW-1:0] b,
                                               logic [PW-1:0] p);
        logic [NL-1:0] res;
        int h;
        res = '0;
        h = 0;
        for (int j = 0; j < NL; j++) begin
            if (j == 0 || p[j-1]) begin
                h = j;
                res[h] = 1'b1;
            end
            if (a[j*LW +: LW] != b[j*LW +: LW]) res[h] = 1'b0;
        end
        return res;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare previous model entry, then drive new stimulus
    task automatic cyc(logic v, logic [DW-1:0] a, logic [DW-1:0] b,
                       logic [PW-1:0] p, string tag);
        @(negedge clk);
        check(exp_tag, 32'(eq_out), 32'(exp_eq));
        check("R7", 32'(out_valid), 32'(exp_vld));
        if (exp_vld) check("R6", 32'(eq_out & ~{exp_part, 1'b1}), 32'd0);
        in_valid = v;
        op_a = a;
        op_b = b;
        part = p;
        exp_vld = v;
        if (v) begin
            exp_eq   = model_eq(a, b, p);
            exp_part = p;
            exp_tag  = tag;
        end else begin
            exp_tag = "R9";
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] m;
        repeat (3) @(negedge clk);
        // R8: outputs cleared while in reset
        check("R8", 32'(eq_out), 32'd0);
        check("R8", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        // R1: single flipped bit per lane, all boundaries open
        for (int k = 0; k < NL; k++) begin
            for (int bp = 0; bp < LW; bp += 3) begin
                a = $urandom();
                cyc(1'b1, a, a ^ (DW'(1) << (k*LW + bp)), 3'b111, "R1");
            end
        end
        a = $urandom();
        cyc(1'b1, a, a, 3'b111, "R1");

        // R2: difference only in lane k+1, boundary k open vs. closed
        for (int k = 0; k < PW; k++) begin
            a = $urandom();
            b = a ^ (DW'(8'h5A) << ((k+1)*LW));
            cyc(1'b1, a, b, PW'(1) << k, "R2");
            cyc(1'b1, a, b, '0, "R2");
        end

        // R3: full-width compare
        a = $urandom();
        cyc(1'b1, a, a, 3'b000, "R3");
        for (int k = 0; k < NL; k++) begin
            cyc(1'b1, a, a ^ (DW'(1) << (k*LW + 7)), 3'b000, "R3");
        end

        // R4: four independent lanes, random forced-equal lanes
        for (int n = 0; n < 16; n++) begin
            a = $urandom();
            m = '0;
            for (int k = 0; k < NL; k++) if (n[k]) m[k*LW +: LW] = '1;
            b = (a & m) | ($urandom() & ~m);
            cyc(1'b1, a, b, 3'b111, "R4");
        end

        // R5: every partition pattern with random lane-equality masks
        for (int p = 0; p < (1 << PW); p++) begin
            for (int n = 0; n < 40; n++) begin
                a = $urandom();
                m = '0;
                for (int k = 0; k < NL; k++) if (($urandom() % 4) != 0) m[k*LW +: LW] = '1;
                b = (a & m) | ($urandom() & ~m);
                cyc(1'b1, a, b, PW'(p), "R5");
            end
        end

        // R9: idle cycles with changing operands must not disturb eq_out
        cyc(1'b1, 32'h11223344, 32'h11223344, 3'b111, "R9");
        for (int n = 0; n < 6; n++) begin
            cyc(1'b0, $urandom(), $urandom(), PW'(n), "R9");
        end
        cyc(1'b1, 32'h0, 32'hFFFF_FFFF, 3'b000, "R7");
        cyc(1'b0, 32'h0, 32'h0, 3'b000, "R7");
        cyc(1'b0, 32'h0, 32'h0, 3'b000, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule